// File: doc/BRIEF.md
# DAC Data Update Controller

This block sits between a register write port and a 10-bit digital-to-analog converter. Software writes a control register and a pair of byte-wide data registers. The block then decides when the staged data is copied into the output latch that drives the converter.

There are two ways to load the latch. With automatic triggering off, writing the high data byte loads it. With automatic triggering on, the latch loads on the rising edge of a hardware event flag, chosen by a select field. A rising edge counts whether or not any interrupt for that event is enabled. The event flags arrive as plain level inputs.

The data pair can hold the 10-bit value right-aligned or left-aligned. A separate enable bit drives the converter-enable output.

Register writes use a valid/ready handshake. The block never applies back-pressure: `req_ready` is always high, and a write takes effect on every clock edge where `req_valid` is high. Reads are combinational through `rd_addr`.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset the control register, both data bytes and `dac_code` are all zero, and `conv_en` is low.
- R2: The control register is at address 0 and has these fields: auto-trigger enable at bit 7, trigger select at bits 6:4, left-align at bit 2, converter enable at bit 0. Bits 3 and 1 always read as zero, whatever value is written to them.
- R3: The low data byte is at address 1. Writing it only stages the byte and never changes `dac_code`.
- R4: The high data byte is at address 2. With auto-trigger at 0, writing it loads `dac_code` at that same clock edge. The load uses the byte being written together with the staged low byte.
- R5: With left-align at 0, the code is {high[1:0], low[7:0]}. With left-align at 1, the code is {high[7:0], low[7:6]}.
- R6: With auto-trigger at 1, a write to the high data byte does not load `dac_code`.
- R7: With auto-trigger at 1, the latch loads at a clock edge when the selected flag is sampled high and was sampled low at the previous edge (or at the first edge after reset). The select codes are: 0 for `evt_flag[0]`, 1 for `evt_flag[1]`, 2 for `evt_flag[2]`.
- R8: A flag that is held high, a falling edge, or an edge on a flag that is not selected does not load `dac_code`. Select codes 3 to 7 never load it.
- R9: `conv_en` equals the converter-enable bit. The latch follows the update rules whether that bit is 0 or 1.
- R10: `req_ready` is always high, so no write is ever refused. A write to address 3 changes nothing, and reading address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A register write is presented |
| req_ready | output | 1 | Write accepted (always high) |
| req_addr | input | 2 | Write address |
| req_wdata | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for `rd_addr` |
| evt_flag | input | 3 | Event flag levels |
| dac_code | output | 10 | Output latch driving the converter |
| conv_en | output | 1 | Converter enable |

## Verification
The assertions assume that `req_addr`, `req_wdata`, `evt_flag` and `rd_addr` are stable around the rising clock edge. They also assume the flags are synchronous levels, so each sampled change of a flag is a real edge.

The bench drives every input at the falling edge. It lets flags rise, fall and stay high for several cycles, changes the select field while flags are active, and sometimes writes the high byte in the same cycle as a trigger edge. It never drives an undefined address or value.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;
  localparam int ADDR_W = 2;
  localparam int SEL_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_LO   = 2'd1,
    A_HI   = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             auto_en;
    logic [SEL_W-1:0] sel;
    logic             left;
    logic             en;
  } ctrl_t;
endpackage

// File: rtl/dac_regs.sv
module dac_regs
  import dac_upd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output ctrl_t             ctrl,
  output logic [DW-1:0]     lo_q,
  output logic [DW-1:0]     hi_next,
  output logic              hi_wr
);
  logic [DW-1:0] hi_q;
  logic          ctrl_wr, lo_wr;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign lo_wr   = wr_en && (wr_addr == A_LO);
  assign hi_wr   = wr_en && (wr_addr == A_HI);
  assign hi_next = hi_wr ? wr_data : hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl.auto_en <= wr_data[7];
        ctrl.sel     <= wr_data[6:4];
        ctrl.left    <= wr_data[2];
        ctrl.en      <= wr_data[0];
      end
      if (lo_wr) lo_q <= wr_data;
      if (hi_wr) hi_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[7]   = ctrl.auto_en;
        rd_data[6:4] = ctrl.sel;
        rd_data[2]   = ctrl.left;
        rd_data[0]   = ctrl.en;
      end
      A_LO:    rd_data = lo_q;
      A_HI:    rd_data = hi_q;
      default: rd_data = '0;
    endcase
  end

  a_r2_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_CTRL) |-> (rd_data[3] == 1'b0 && rd_data[1] == 1'b0));
  a_r10_none_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_NONE) |-> (rd_data == '0));
endmodule

// File: rtl/dac_edge.sv
module dac_edge
  import dac_upd_pkg::*;
#(
  parameter int N_EVT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] flag,
  input  logic [SEL_W-1:0] sel,
  output logic             trig
);
  logic [N_EVT-1:0] prev_q;
  logic [N_EVT-1:0] pulse;

  for (genvar g = 0; g < N_EVT; g++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= flag[g];
    end
    assign pulse[g] = flag[g] & ~prev_q[g];

    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      pulse[g] |=> !pulse[g]);
  end

  always_comb begin
    trig = 1'b0;
    for (int i = 0; i < N_EVT; i++)
      if (sel == SEL_W'(i)) trig = pulse[i];
  end

  a_r8_bad_sel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) >= N_EVT) |-> !trig);
endmodule

// File: rtl/dac_latch.sv
module dac_latch #(
  parameter int DW     = 8,
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              left,
  input  logic [DW-1:0]     hi,
  input  logic [DW-1:0]     lo,
  output logic [CODE_W-1:0] code
);
  localparam int XW = CODE_W - DW;

  logic [CODE_W-1:0] aligned;

  assign aligned = left ? {hi, lo[DW-1 -: XW]} : {hi[XW-1:0], lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code <= '0;
    else if (load) code <= aligned;
  end
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dac_upd_pkg::*;
#(
  parameter int DW     = 8,
  parameter int CODE_W = 10,
  parameter int N_EVT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [N_EVT-1:0]  evt_flag,
  output logic [CODE_W-1:0] dac_code,
  output logic              conv_en
);
  ctrl_t         ctrl;
  logic [DW-1:0] lo_q, hi_next;
  logic          hi_wr, trig, load, wr_en;

  assign req_ready = 1'b1;
  assign wr_en     = req_valid & req_ready;

  dac_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(req_addr),
    .wr_data(req_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .ctrl(ctrl), .lo_q(lo_q), .hi_next(hi_next), .hi_wr(hi_wr)
  );

  dac_edge #(.N_EVT(N_EVT)) u_edge (
    .clk(clk), .rst_n(rst_n), .flag(evt_flag), .sel(ctrl.sel), .trig(trig)
  );

  assign load = ctrl.auto_en ? trig : hi_wr;

  dac_latch #(.DW(DW), .CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(load), .left(ctrl.left),
    .hi(hi_next), .lo(lo_q), .code(dac_code)
  );

  assign conv_en = ctrl.en;

  a_r3_lo_write_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_addr == A_LO && !(ctrl.auto_en && trig)) |=> $stable(dac_code));
  a_r6_auto_hi_write_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.auto_en && !trig) |=> $stable(dac_code));
  a_r9_enable_matches_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_CTRL) |-> (conv_en == rd_data[0]));
  a_r8_held_flag_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.auto_en && $stable(ctrl.sel) && $stable(evt_flag)) |=> $stable(dac_code));
endmodule

// File: tb/sim_dac_update_ctrl.sv
`timescale 1ns/1ps
module sim_dac_update_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [2:0] evt_flag = '0;
  logic [9:0] dac_code;
  logic       conv_en;

  always #2 clk = ~clk;

  dac_update_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .evt_flag(evt_flag), .dac_code(dac_code),
    .conv_en(conv_en)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R1";

  // behavioural reference model
  int m_ctrl = 0, m_lo = 0, m_hi = 0, m_code = 0;
  int m_prev[3] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_lo = 0; m_hi = 0; m_code = 0;
      foreach (m_prev[k]) m_prev[k] = 0;
    end else begin
      int  hi_use, sel, do_load;
      bit  wr;
      wr     = (req_valid === 1'b1);
      hi_use = (wr && req_addr == 2) ? int'(req_wdata) : m_hi;
      sel    = (m_ctrl / 16) % 8;
      do_load = 0;
      if (m_ctrl >= 128) begin
        if (sel < 3 && evt_flag[sel] == 1'b1 && m_prev[sel] == 0) do_load = 1;
      end else if (wr && req_addr == 2) do_load = 1;
      if (do_load) begin
        if ((m_ctrl / 4) % 2 == 1) m_code = hi_use * 4 + m_lo / 64;
        else                       m_code = (hi_use % 4) * 256 + m_lo;
      end
      if (wr) begin
        case (req_addr)
          2'd0: m_ctrl = int'(req_wdata) & 'hF5;
          2'd1: m_lo = int'(req_wdata);
          2'd2: m_hi = int'(req_wdata);
          default: ;
        endcase
      end
      for (int k = 0; k < 3; k++) m_prev[k] = int'(evt_flag[k]);
    end
  end

  function automatic int model_read(input int a);
    case (a)
      0: return m_ctrl;
      1: return m_lo;
      2: return m_hi;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("dac_code", int'(dac_code), m_code);
    chk("conv_en", int'(conv_en), m_ctrl % 2);
    chk("rd_data", int'(rd_data), model_read(int'(rd_addr)));
    chk("req_ready R10", int'(req_ready), 1);
  endtask

  task automatic step(input bit v, input int a, input int d, input int e);
    @(negedge clk);
    compare();
    req_valid = v;
    req_addr  = 2'(a);
    req_wdata = 8'(d);
    evt_flag  = 3'(e);
    rd_addr   = rd_addr + 2'd1;
  endtask

  task automatic wr(input int a, input int d, input int e);
    step(1'b1, a, d, e);
  endtask

  task automatic idle(input int e);
    step(1'b0, 0, 0, e);
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R1"; repeat (4) idle(0);
    phase = "R2"; wr(0, 'hFF, 0); repeat (4) idle(0); wr(0, 'h0A, 0); repeat (4) idle(0);
    wr(0, 'h00, 0); idle(0);
    phase = "R3"; wr(1, 'hC3, 0); wr(1, 'h5A, 0); repeat (4) idle(0);
    phase = "R4"; wr(1, 'hFF, 0); wr(2, 'h81, 0); idle(0); wr(2, 'h02, 0); idle(0);
    phase = "R5"; wr(0, 'h04, 0); wr(1, 'hC0, 0); wr(2, 'hA5, 0); idle(0);
    wr(1, 'h40, 0); wr(2, 'h3C, 0); idle(0);
    wr(0, 'h00, 0); wr(1, 'h77, 0); wr(2, 'hFE, 0); idle(0);
    phase = "R9"; wr(0, 'h01, 0); wr(1, 'h12, 0); wr(2, 'h03, 0); idle(0);
    wr(0, 'h00, 0); wr(2, 'h01, 0); idle(0);
    phase = "R6"; wr(0, 'h80, 0); wr(1, 'h99, 0); wr(2, 'h44, 0); repeat (3) idle(0);
    phase = "R7";
    for (int s = 0; s < 3; s++) begin
      wr(0, 'h80 | (s * 16), 0);
      wr(1, 'h10 + s, 0); wr(2, 'h20 + s, 0);
      idle(0); idle(1 << s); idle(1 << s); idle(0); idle(0);
      wr(2, 'h31 + s, 1 << s); idle(0);
    end
    phase = "R8";
    wr(0, 'h90, 0); wr(2, 'h55, 0); idle(0);
    idle(5); idle(5); idle(0); idle(4); idle(1);
    for (int s = 3; s < 8; s++) begin
      wr(0, 'h80 | (s * 16), 0); wr(2, s, 0);
      idle(7); idle(0); idle(7); idle(0);
    end
    phase = "R10"; wr(3, 'hFF, 0); repeat (4) idle(0);
    phase = "mixed";
    for (int i = 0; i < 600; i++)
      step(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 7)));
    phase = "R1";
    @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
    @(negedge clk); compare();
    @(negedge clk); rst_n = 1'b1; repeat (3) idle(0);
    idle(0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule